// File: doc/BRIEF.md
# Aggregated Error Interrupt Collector

This block gathers 64 interrupt sources into a single summary interrupt line. The lowest 21 sources arrive on dedicated active-high wires and behave as level interrupts. The upper 43 sources have no wires. Each is raised when a message-signalled write stores its source number into a doorbell register, so every such write is one rising-edge event.

Every source owns one latched cause bit and one mask bit. The 64 bits of each kind are split into two 32-bit words, and source n sits in word n/32 at bit n%32. Software reaches the words over a simple 32-bit register bus. The offsets are: cause words at 0x00 and 0x04, mask words at 0x20 and 0x24, and the doorbell at 0x30. Cause bits are cleared by writing 1 to them. Mask bits use 1 to block a source and 0 to let it through. The summary output is high while any unmasked cause bit is set.

Top module: `err_irq_collector`

## Requirements
- R1: A synchronous active-low reset clears every cause bit, sets every mask bit to 1, and holds the summary output low.
- R2: Cause words read back at 0x00 (sources 0..31) and 0x04 (sources 32..63), and mask words at 0x20 and 0x24, with source n at bit n%32. Reads of any other offset, the doorbell offset 0x30 included, return 0.
- R3: Writing a cause word clears each bit written as 1 on the next clock edge, and leaves each bit written as 0 unchanged.
- R4: The summary output is 1 exactly when some cause bit is 1 and its mask bit is 0.
- R5: A write to a mask word replaces all 32 bits of it from the next clock edge. A mask bit of 1 blocks that source from the summary output.
- R6: A write of value V, with 21 <= V <= 63, to offset 0x30 sets cause bit V on the next clock edge. This reaches word 0 for V up to 31 and word 1 for V from 32 upward.
- R7: A doorbell write whose value is below 21 or above 63 changes no cause bit.
- R8: While wired input i (0..20) is high, its cause bit is set on every clock edge. A set request beats a write-1-to-clear of the same bit in the same cycle, so a clear has effect only once the input is low.
- R9: Writing all-ones to both cause words and both mask words, with the wired inputs low, leaves every cause bit 0, every mask bit 1 and the summary output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wired_irq | input | 21 | Active-high level interrupt wires for sources 0..20 |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 8 | Byte offset for the read and the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Summary interrupt |

## Verification
The bench probes the doorbell range edges. Value 20 must do nothing and value 21 must land in word 0. Values 31 and 32 sit on either side of the word boundary, and 63 is the top value. Values 64 and all-ones must be ignored. A design with an off-by-one range check or a wrong word split would set a stray cause bit or miss one. A clear is issued while a wired input is still high, and a design that let the clear win would drop a live level interrupt. Other directed cases cover a zero-valued clear, a mask change with no cause change, and reads of unused offsets. Seeded random traffic mixes all write targets with random wire activity and checks each cycle against a bench model.

// File: rtl/err_irq_pkg.sv
// Package: shared offsets and the decoded-target type of the error
// interrupt collector. Assumes a byte-addressed bus with 4-byte words.
package err_irq_pkg;
    localparam int CAUSE_BASE  = 'h00;
    localparam int MASK_BASE   = 'h20;
    localparam int BELL_OFFSET = 'h30;
    localparam int WORD_BYTES  = 4;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_CAUSE,
        TGT_MASK,
        TGT_BELL
    } reg_tgt_e;
endpackage

// File: rtl/err_irq_decode.sv
// Module: err_irq_decode
// Maps a byte offset onto a register target and a word index.
// Assumes the cause and mask words sit at consecutive 4-byte steps.
module err_irq_decode
    import err_irq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int N_WORDS = 2,
    localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_tgt_e          tgt,
    output logic [IDX_W-1:0]  word_idx
);
    // Compare the offset with every register location.
    always_comb begin
        tgt      = TGT_NONE;
        word_idx = '0;
        if (addr == ADDR_W'(BELL_OFFSET))
            tgt = TGT_BELL;
        for (int k = 0; k < N_WORDS; k++) begin
            if (addr == ADDR_W'(CAUSE_BASE + WORD_BYTES * k)) begin
                tgt      = TGT_CAUSE;
                word_idx = IDX_W'(k);
            end
            if (addr == ADDR_W'(MASK_BASE + WORD_BYTES * k)) begin
                tgt      = TGT_MASK;
                word_idx = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/err_irq_bell.sv
// Module: err_irq_bell
// Turns a doorbell write value into a one-hot set request.
// Assumes only values in [FIRST_MSG, N_SRC-1] are legal; others are dropped.
module err_irq_bell #(
    parameter int N_SRC     = 64,
    parameter int FIRST_MSG = 21,
    parameter int DATA_W    = 32
) (
    input  logic              bell_wr,
    input  logic [DATA_W-1:0] bell_val,
    output logic [N_SRC-1:0]  set_vec,
    output logic              hit
);
    // One comparator per source bit. Wired-range bits are never set here.
    for (genvar b = 0; b < N_SRC; b++) begin : g_bit
        if (b < FIRST_MSG) begin : g_wired
            assign set_vec[b] = 1'b0;
        end else begin : g_msg
            assign set_vec[b] = bell_wr && (bell_val == DATA_W'(b));
        end
    end

    // Flag a legal doorbell write.
    assign hit = |set_vec;
endmodule

// File: rtl/err_irq_word.sv
// Module: err_irq_word
// One 32-bit slice of cause and mask state, plus its pending flag.
// Assumes set_vec already merges the wired levels and doorbell requests.
// Set requests take priority over clears.
module err_irq_word #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_vec,
    input  logic [WORD_W-1:0] clr_vec,
    input  logic              mask_wr,
    input  logic [WORD_W-1:0] mask_wdata,
    output logic [WORD_W-1:0] cause,
    output logic [WORD_W-1:0] mask,
    output logic              pending
);
    // Cause latch: clear on 1, then OR in the new set requests.
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= (cause & ~clr_vec) | set_vec;
    end

    // Mask word: reset to all blocked, replaced whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_wr) mask <= mask_wdata;
    end

    // Any unmasked cause bit makes this slice pending.
    assign pending = |(cause & ~mask);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cause == '0 && mask == '1));
    a_r3_clear_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((cause & $past(clr_vec & ~set_vec)) == '0));
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause & $past(cause & ~clr_vec)) == $past(cause & ~clr_vec)));
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((cause & $past(set_vec)) == $past(set_vec)));
    a_r5_mask_replace: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask == $past(mask_wdata)));
endmodule

// File: rtl/err_irq_collector.sv
// Module: err_irq_collector (top)
// Collects wired level interrupts and doorbell events into latched cause
// bits, gates them by mask bits and drives one summary interrupt.
// Assumes one bus access per cycle and wired inputs already synchronous.
module err_irq_collector
    import err_irq_pkg::*;
#(
    parameter int N_WIRED = 21,
    parameter int N_WORDS = 2,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_WIRED-1:0] wired_irq,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               irq_out
);
    localparam int N_SRC = N_WORDS * WORD_W;
    localparam int SRC_W = $clog2(N_SRC);
    localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam logic [N_SRC-1:0] MSG_BITS = {N_SRC{1'b1}} << N_WIRED;

    reg_tgt_e            tgt;
    logic [IDX_W-1:0]    word_idx;
    logic                bell_wr;
    logic                bell_hit;
    logic [N_SRC-1:0]    bell_set;
    logic [N_SRC-1:0]    set_flat;
    logic [N_SRC-1:0]    cause_flat;
    logic [N_SRC-1:0]    mask_flat;
    logic [WORD_W-1:0]   cause_w [N_WORDS];
    logic [WORD_W-1:0]   mask_w  [N_WORDS];
    logic [N_WORDS-1:0]  pend_w;

    err_irq_decode #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u_decode (
        .addr     (reg_addr),
        .tgt      (tgt),
        .word_idx (word_idx)
    );

    // A doorbell write needs the strobe and the doorbell offset.
    assign bell_wr = reg_wr && (tgt == TGT_BELL);

    err_irq_bell #(.N_SRC(N_SRC), .FIRST_MSG(N_WIRED), .DATA_W(WORD_W)) u_bell (
        .bell_wr  (bell_wr),
        .bell_val (reg_wdata),
        .set_vec  (bell_set),
        .hit      (bell_hit)
    );

    // Merge the wired levels (zero-extended) with doorbell requests.
    assign set_flat = N_SRC'(wired_irq) | bell_set;

    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        logic [WORD_W-1:0] clr_k;
        logic              mwr_k;

        // Route the write data as a clear vector to the addressed word.
        assign clr_k = (reg_wr && tgt == TGT_CAUSE && word_idx == IDX_W'(k))
                       ? reg_wdata : '0;
        // Strobe the addressed mask word.
        assign mwr_k = reg_wr && tgt == TGT_MASK && word_idx == IDX_W'(k);

        err_irq_word #(.WORD_W(WORD_W)) u_word (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_vec    (set_flat[k*WORD_W +: WORD_W]),
            .clr_vec    (clr_k),
            .mask_wr    (mwr_k),
            .mask_wdata (reg_wdata),
            .cause      (cause_w[k]),
            .mask       (mask_w[k]),
            .pending    (pend_w[k])
        );

        // Flatten the per-word state for the range checks below.
        assign cause_flat[k*WORD_W +: WORD_W] = cause_w[k];
        assign mask_flat[k*WORD_W +: WORD_W]  = mask_w[k];
    end

    // Summary line: any pending slice.
    assign irq_out = |pend_w;

    // Read mux: cause or mask word, otherwise zero.
    always_comb begin
        reg_rdata = '0;
        case (tgt)
            TGT_CAUSE: reg_rdata = cause_w[word_idx];
            TGT_MASK:  reg_rdata = mask_w[word_idx];
            default:   reg_rdata = '0;
        endcase
    end

    a_r6_bell_sets: assert property (@(posedge clk) disable iff (!rst_n)
        bell_hit |=> cause_flat[$past(reg_wdata[SRC_W-1:0])]);
    a_r7_bell_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_wr && !bell_hit) |=> ((cause_flat & ~$past(cause_flat) & MSG_BITS) == '0));
    a_r4_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_flat == '1) |-> !irq_out);
    a_r4_set_unmasked_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cause_flat & ~mask_flat)) |-> irq_out);
endmodule

// File: tb/tb_err_irq_collector.sv
`timescale 1ns/100ps
// Bench: directed corner cases, then seeded random traffic, all checked
// against a bench-side model of cause and mask state.
module tb_err_irq_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] wired_irq = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] exp_cause;
    logic [63:0] exp_mask;

    err_irq_collector dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wired_irq (wired_irq),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    always #4 clk = ~clk;

    // Next cause state from the requirements.
    function automatic logic [63:0] next_cause(input logic [63:0] cur,
            input logic wr, input logic [7:0] a, input logic [31:0] d,
            input logic [20:0] w);
        logic [63:0] clr = '0;
        logic [63:0] set = {43'b0, w};
        if (wr && a == 8'h00) clr[31:0]  = d;
        if (wr && a == 8'h04) clr[63:32] = d;
        if (wr && a == 8'h30 && d >= 32'd21 && d <= 32'd63) set[d[5:0]] = 1'b1;
        return (cur & ~clr) | set;
    endfunction

    function automatic logic [63:0] next_mask(input logic [63:0] cur,
            input logic wr, input logic [7:0] a, input logic [31:0] d);
        logic [63:0] m = cur;
        if (wr && a == 8'h20) m[31:0]  = d;
        if (wr && a == 8'h24) m[63:32] = d;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // One clock with an optional write; called just after a falling edge.
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        exp_cause = next_cause(exp_cause, wr, a, d, wired_irq);
        exp_mask  = next_mask(exp_mask, wr, a, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        chk({tag, " R4 irq"}, 64'(irq_out), 64'(|(exp_cause & ~exp_mask)));
        rd(8'h00, v); chk({tag, " R2 cause0"}, 64'(v), 64'(exp_cause[31:0]));
        rd(8'h04, v); chk({tag, " R2 cause1"}, 64'(v), 64'(exp_cause[63:32]));
        rd(8'h20, v); chk({tag, " R2 mask0"}, 64'(v), 64'(exp_mask[31:0]));
        rd(8'h24, v); chk({tag, " R2 mask1"}, 64'(v), 64'(exp_mask[63:32]));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        exp_cause = '0;
        exp_mask  = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq low", 64'(irq_out), 64'd0);
        rd(8'h00, v); chk("R1 cause0", 64'(v), 64'd0);
        rd(8'h04, v); chk("R1 cause1", 64'(v), 64'd0);
        rd(8'h20, v); chk("R1 mask0", 64'(v), 64'hFFFF_FFFF);
        rd(8'h24, v); chk("R1 mask1", 64'(v), 64'hFFFF_FFFF);

        // R6: lowest doorbell value, masked so summary stays low
        step(1'b1, 8'h30, 32'd21);
        rd(8'h00, v); chk("R6 bell 21", 64'(v), 64'h0020_0000);
        chk("R4 masked no irq", 64'(irq_out), 64'd0);

        // R6: word boundary and top value
        step(1'b1, 8'h30, 32'd31);
        step(1'b1, 8'h30, 32'd32);
        step(1'b1, 8'h30, 32'd63);
        rd(8'h00, v); chk("R6 bell 31", 64'(v), 64'h8020_0000);
        rd(8'h04, v); chk("R6 bell 32 63", 64'(v), 64'h8000_0001);

        // R7: out-of-range doorbell values
        step(1'b1, 8'h30, 32'd20);
        step(1'b1, 8'h30, 32'd64);
        step(1'b1, 8'h30, 32'hFFFF_FFFF);
        step(1'b1, 8'h30, 32'd0);
        rd(8'h00, v); chk("R7 ignored lo", 64'(v), 64'h8020_0000);
        rd(8'h04, v); chk("R7 ignored hi", 64'(v), 64'h8000_0001);

        // R5: unmask bit 21 only, summary rises
        step(1'b1, 8'h20, 32'hFFDF_FFFF);
        rd(8'h20, v); chk("R5 mask readback", 64'(v), 64'hFFDF_FFFF);
        chk("R5 unmask raises irq", 64'(irq_out), 64'd1);

        // R3: zero write keeps, one write clears
        step(1'b1, 8'h00, 32'd0);
        rd(8'h00, v); chk("R3 zero keeps", 64'(v), 64'h8020_0000);
        step(1'b1, 8'h00, 32'h0020_0000);
        rd(8'h00, v); chk("R3 one clears", 64'(v), 64'h8000_0000);
        chk("R4 irq drops", 64'(irq_out), 64'd0);

        // R5: re-mask a pending source
        step(1'b1, 8'h24, 32'h7FFF_FFFF);
        chk("R5 unmask bit 63", 64'(irq_out), 64'd1);
        step(1'b1, 8'h24, 32'hFFFF_FFFF);
        chk("R5 mask blocks", 64'(irq_out), 64'd0);

        // R8: wired level, clear while high does not stick
        wired_irq = 21'h20;
        step(1'b1, 8'h20, 32'hFFFF_FFDF);
        rd(8'h00, v); chk("R8 wired sets", 64'(v[5]), 64'd1);
        chk("R8 irq", 64'(irq_out), 64'd1);
        step(1'b1, 8'h00, 32'h20);
        rd(8'h00, v); chk("R8 clear loses to level", 64'(v[5]), 64'd1);
        wired_irq = '0;
        step(1'b0, 8'h00, 32'h0);
        rd(8'h00, v); chk("R8 latched after drop", 64'(v[5]), 64'd1);
        step(1'b1, 8'h00, 32'h20);
        rd(8'h00, v); chk("R8 clear after drop", 64'(v[5]), 64'd0);

        // R2: undefined offsets and doorbell read as zero
        rd(8'h08, v); chk("R2 offset 08", 64'(v), 64'd0);
        rd(8'h30, v); chk("R2 offset 30", 64'(v), 64'd0);
        rd(8'h40, v); chk("R2 offset 40", 64'(v), 64'd0);

        // R9: all-ones to all four words
        step(1'b1, 8'h30, 32'd40);
        step(1'b1, 8'h20, 32'h0);
        step(1'b1, 8'h00, 32'hFFFF_FFFF);
        step(1'b1, 8'h04, 32'hFFFF_FFFF);
        step(1'b1, 8'h20, 32'hFFFF_FFFF);
        step(1'b1, 8'h24, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R9 cause0 clear", 64'(v), 64'd0);
        rd(8'h04, v); chk("R9 cause1 clear", 64'(v), 64'd0);
        rd(8'h20, v); chk("R9 mask0 set", 64'(v), 64'hFFFF_FFFF);
        rd(8'h24, v); chk("R9 mask1 set", 64'(v), 64'hFFFF_FFFF);
        chk("R9 irq low", 64'(irq_out), 64'd0);

        // Model-based random traffic
        check_all("sync");
        v = $urandom(32'd2024);
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int sel = int'($urandom_range(0, 7));
            case (sel)
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h20;
                3: a = 8'h24;
                4, 5: a = 8'h30;
                6: a = 8'h08;
                default: a = 8'h3C;
            endcase
            d = $urandom();
            if (a == 8'h30)
                d = ($urandom_range(0, 9) == 0) ? $urandom() : 32'($urandom_range(0, 70));
            wired_irq = 21'($urandom() & $urandom() & $urandom());
            step(1'($urandom_range(0, 5) != 0), a, d);
            check_all("random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule